// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block shapes the word a flash device hands back on a read while an internal program or erase is running. The host polls the device during that time, and the returned word carries two progress indicators in place of stored data. Bit 7 is a polarity flag: during a program it reads as the inverse of the bit 7 value being written, and during an erase it reads as 0. Bit 6 is a flip bit that changes value on every read for as long as the operation runs. When the busy flag falls, the word is once again the plain array read data. An erased array reads all ones, so bit 7 reads 1 at that point.

A command sequencer drives the busy flag once the last write strobe of a command has been accepted. That is the fourth strobe for a word program and the sixth for a sector or block erase. The sequencer also drives the operation kind and the bit 7 value of the word being written. This block takes the kind and the bit 7 value in the first busy cycle and keeps them for the whole operation. The array read path feeds the data input, and the read strobe marks each host read.

Top module: `flash_wstat_gen`

## Requirements
- R1: While `busy_i` is 0, `rd_data_o` equals `arr_data_i` on every bit, in the same cycle.
- R2: During a program operation (`op_erase_i` = 0 when sampled), bit 7 of `rd_data_o` is the inverse of the sampled `prog_msb_i`.
- R3: During an erase operation (`op_erase_i` = 1 when sampled), bit 7 of `rd_data_o` is 0. Once `busy_i` falls, bit 7 follows `arr_data_i[7]` again, so an erased array reads 1.
- R4: While busy, bit 6 of `rd_data_o` shows the flip bit. The flip bit is 0 in the first busy cycle of each operation. Every clock cycle with `busy_i` and `rd_stb_i` both high inverts it for the following cycle, so consecutive reads alternate 0, 1, 0, ...
- R5: While busy, bit 6 keeps its value across every cycle in which `rd_stb_i` is 0.
- R6: Bits other than 6 and 7 always pass `arr_data_i` through, busy or not.
- R7: The operation kind and the bit 7 value are sampled in the first cycle that `busy_i` is high, and that first cycle already uses them. Changes to `op_erase_i` or `prog_msb_i` later in the same busy period have no effect on `rd_data_o`.
- R8: After `busy_i` falls, bit 6 stops flipping and follows `arr_data_i[6]`. The next operation starts its flip sequence from 0 again, whatever the previous operation left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal program or erase in progress |
| op_erase_i | input | 1 | Operation kind: 0 program, 1 erase |
| prog_msb_i | input | 1 | Bit 7 of the word being programmed |
| rd_stb_i | input | 1 | One cycle per host read |
| arr_data_i | input | DW (16) | Array read data |
| rd_data_o | output | DW (16) | Word returned to the host |

## Verification
The assertions assume that `busy_i` stays high as one unbroken interval for each operation. They also assume that a read strobe lasts exactly the cycle in which the host samples the data. The properties on the flip bit compare each cycle with the one before, so a gap in busy would reset the sequence in a way the properties tolerate but the bench model would not. For that reason, every task holds busy for a whole operation. The bench also drives each strobe for a single cycle, changes the inputs only on the falling clock edge, and reads the output before the next rising edge.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} op_kind_e;

  function automatic logic poll_value(input op_kind_e kind, input logic msb);
    return (kind == OP_ERASE) ? 1'b0 : ~msb;
  endfunction

  function automatic logic flip_next(input logic busy, input logic strobe,
                                     input logic cur);
    if (!busy) return 1'b0;
    return strobe ? ~cur : cur;
  endfunction
endpackage

// File: rtl/wstat_capture.sv
module wstat_capture
  import wstat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busy_i,
  input  logic     op_erase_i,
  input  logic     prog_msb_i,
  output logic     op_start_o,
  output op_kind_e kind_eff_o,
  output logic     msb_eff_o
);
  logic     busy_q;
  op_kind_e kind_q;
  logic     msb_q;

  assign op_start_o = busy_i & ~busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= OP_PROG;
      msb_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (op_start_o) begin
        kind_q <= op_kind_e'(op_erase_i);
        msb_q  <= prog_msb_i;
      end
    end
  end

  assign kind_eff_o = op_start_o ? op_kind_e'(op_erase_i) : kind_q;
  assign msb_eff_o  = op_start_o ? prog_msb_i : msb_q;
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle
  import wstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rd_stb_i,
  output logic flip_o
);
  logic flip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flip_q <= 1'b0;
    else        flip_q <= flip_next(busy_i, rd_stb_i, flip_q);
  end

  assign flip_o = flip_q;
endmodule

// File: rtl/wstat_merge.sv
module wstat_merge #(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int FLIP_BIT = 6
) (
  input  logic          busy_i,
  input  logic          poll_i,
  input  logic          flip_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign rd_data_o[i] = busy_i ? poll_i : arr_data_i[i];
    end else if (i == FLIP_BIT) begin : g_flip
      assign rd_data_o[i] = busy_i ? flip_i : arr_data_i[i];
    end else begin : g_pass
      assign rd_data_o[i] = arr_data_i[i];
    end
  end
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
  import wstat_pkg::*;
#(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int FLIP_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          op_erase_i,
  input  logic          prog_msb_i,
  input  logic          rd_stb_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int HI_BIT = (POLL_BIT > FLIP_BIT) ? POLL_BIT : FLIP_BIT;

  if (HI_BIT >= DW || POLL_BIT == FLIP_BIT) begin : g_bad_cfg
    initial $error("flash_wstat_gen: status bit positions invalid for DW");
  end

  logic     op_start;
  op_kind_e kind_eff;
  logic     msb_eff;
  logic     flip_bit;
  logic     poll_bit;

  wstat_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_i),
    .op_erase_i (op_erase_i),
    .prog_msb_i (prog_msb_i),
    .op_start_o (op_start),
    .kind_eff_o (kind_eff),
    .msb_eff_o  (msb_eff)
  );

  wstat_toggle u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy_i),
    .rd_stb_i (rd_stb_i),
    .flip_o   (flip_bit)
  );

  assign poll_bit = poll_value(kind_eff, msb_eff);

  wstat_merge #(.DW(DW), .POLL_BIT(POLL_BIT), .FLIP_BIT(FLIP_BIT)) u_mrg (
    .busy_i     (busy_i),
    .poll_i     (poll_bit),
    .flip_i     (flip_bit),
    .arr_data_i (arr_data_i),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk
  import wstat_pkg::*;
#(
  parameter int DW       = 16,
  parameter int POLL_BIT = 7,
  parameter int FLIP_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_i,
  input logic          rd_stb_i,
  input logic [DW-1:0] arr_data_i,
  input logic [DW-1:0] rd_data_o,
  input logic          op_start,
  input op_kind_e      kind_eff,
  input logic          msb_eff
);
  localparam logic [DW-1:0] PASS_MASK =
    ~((DW'(1) << POLL_BIT) | (DW'(1) << FLIP_BIT));

  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> rd_data_o == arr_data_i);

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && kind_eff == OP_PROG) |-> rd_data_o[POLL_BIT] == ~msb_eff);

  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && kind_eff == OP_ERASE) |-> rd_data_o[POLL_BIT] == 1'b0);

  assert_flip_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> rd_data_o[FLIP_BIT] == 1'b0);

  assert_flip_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_stb_i) |=> (!busy_i || rd_data_o[FLIP_BIT] != $past(rd_data_o[FLIP_BIT])));

  assert_flip_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !rd_stb_i) |=> (!busy_i || $stable(rd_data_o[FLIP_BIT])));

  assert_low_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & PASS_MASK) == (arr_data_i & PASS_MASK));

  assert_kind_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !op_start) |-> ($stable(kind_eff) && $stable(msb_eff)));
endmodule

bind flash_wstat_gen flash_wstat_chk #(
  .DW(DW), .POLL_BIT(POLL_BIT), .FLIP_BIT(FLIP_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (busy_i),
  .rd_stb_i   (rd_stb_i),
  .arr_data_i (arr_data_i),
  .rd_data_o  (rd_data_o),
  .op_start   (op_start),
  .kind_eff   (kind_eff),
  .msb_eff    (msb_eff)
);

// File: tb/flash_wstat_gen_tb_top.sv
module flash_wstat_gen_tb_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          busy_i;
  logic          op_erase_i;
  logic          prog_msb_i;
  logic          rd_stb_i;
  logic [DW-1:0] arr_data_i;
  logic [DW-1:0] rd_data_o;

  int n_chk = 0;
  int n_err = 0;
  logic exp_flip;

  always #2 clk = ~clk;

  flash_wstat_gen #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .op_erase_i(op_erase_i),
    .prog_msb_i(prog_msb_i), .rd_stb_i(rd_stb_i), .arr_data_i(arr_data_i),
    .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected word during busy: low bits pass, bit7 poll, bit6 flip
  function automatic logic [DW-1:0] busy_word(input logic [DW-1:0] arr,
                                              input logic p, input logic f);
    logic [DW-1:0] w;
    w = arr;
    w[7] = p;
    w[6] = f;
    return w;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic go_busy(input logic erase, input logic msb);
    step();
    busy_i = 1'b1; op_erase_i = erase; prog_msb_i = msb; rd_stb_i = 1'b0;
    exp_flip = 1'b0;
  endtask

  // read: strobe one cycle, sample in that cycle
  task automatic do_read(input string req, input logic [DW-1:0] arr,
                         input logic p);
    step();
    arr_data_i = arr; rd_stb_i = 1'b1;
    #1 check(req, rd_data_o, busy_word(arr, p, exp_flip));
    exp_flip = ~exp_flip;
    step();
    rd_stb_i = 1'b0;
  endtask

  task automatic go_idle();
    step();
    busy_i = 1'b0; rd_stb_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; busy_i = 1'b0; op_erase_i = 1'b0; prog_msb_i = 1'b0;
    rd_stb_i = 1'b0; arr_data_i = 16'h1234;
    repeat (3) step();
    rst_n = 1'b1;
    #1 check("R1 reset", rd_data_o, 16'h1234);
  endtask

  task automatic t_idle();
    logic [DW-1:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h5A3C};
    foreach (pats[k]) begin
      step();
      arr_data_i = pats[k]; rd_stb_i = k[0];
      #1 check("R1 idle pass", rd_data_o, pats[k]);
    end
    step(); rd_stb_i = 1'b0;
  endtask

  task automatic t_program();
    go_busy(1'b0, 1'b1);
    #1 check("R2 prog msb1 first cycle", rd_data_o, busy_word(arr_data_i, 1'b0, 1'b0));
    do_read("R2 prog read", 16'hFFFF, 1'b0);
    do_read("R4 prog 2nd read", 16'h00C0, 1'b0);
    do_read("R6 prog low bits", 16'h3F15, 1'b0);
    go_idle();
    arr_data_i = 16'h0080;
    #1 check("R2 prog done true data", rd_data_o, 16'h0080);
    go_busy(1'b0, 1'b0);
    do_read("R2 prog msb0", 16'h0000, 1'b1);
    go_idle();
  endtask

  task automatic t_erase();
    go_busy(1'b1, 1'b0);
    do_read("R3 erase poll", 16'hFFFF, 1'b0);
    do_read("R3 erase poll 2", 16'hFFFF, 1'b0);
    do_read("R4 erase flip", 16'hFFFF, 1'b0);
    go_idle();
    arr_data_i = 16'hFFFF;
    #1 check("R3 erase done reads 1", rd_data_o, 16'hFFFF);
  endtask

  task automatic t_hold();
    go_busy(1'b1, 1'b0);
    do_read("R4 hold pre", 16'h0000, 1'b0);
    repeat (5) begin
      step();
      arr_data_i = 16'h0040;
      #1 check("R5 hold no strobe", rd_data_o, busy_word(16'h0040, 1'b0, exp_flip));
    end
    do_read("R5 hold post", 16'h0000, 1'b0);
    go_idle();
  endtask

  task automatic t_capture();
    go_busy(1'b0, 1'b0);
    step();
    op_erase_i = 1'b1; prog_msb_i = 1'b1;
    #1 check("R7 late change ignored", rd_data_o, busy_word(arr_data_i, 1'b1, exp_flip));
    do_read("R7 still program", 16'h1111, 1'b1);
    go_idle();
    op_erase_i = 1'b1;
    go_busy(1'b1, 1'b1);
    #1 check("R7 new op resampled", rd_data_o, busy_word(arr_data_i, 1'b0, 1'b0));
    go_idle();
  endtask

  task automatic t_restart();
    go_busy(1'b0, 1'b1);
    do_read("R8 odd reads a", 16'h0000, 1'b0);
    go_idle();
    repeat (2) begin
      step();
      rd_stb_i = 1'b1; arr_data_i = 16'h0040;
      #1 check("R8 idle bit6 array", rd_data_o, 16'h0040);
    end
    step(); rd_stb_i = 1'b0; arr_data_i = 16'h0000;
    #1 check("R8 idle bit6 array 0", rd_data_o, 16'h0000);
    go_busy(1'b0, 1'b1);
    do_read("R8 restart from 0", 16'h0000, 1'b0);
    do_read("R8 restart flips", 16'h0000, 1'b0);
    go_idle();
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_program();
    t_erase();
    t_hold();
    t_capture();
    t_restart();
    repeat (2) step();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule